// File: doc/BRIEF.md
# FIFO Event Interrupt Register Unit

This unit collects four level-type event signals from a FIFO-based peripheral and turns them into one interrupt request. It latches each event on its rising edge into a status bit. Software sees and controls the unit through three 32-bit registers on a simple register bus: a master enable word, an event status word and a per-source enable word.

Software clears a latched event by writing a 1 to its status bit. This write toggles the bit rather than forcing it to zero. A hardware event that arrives in the same cycle as such a write wins, so no edge is lost. The interrupt line rises when the master enable is on and at least one latched event has its source enabled.

Bus reads are registered. The bus returns data one clock after the read strobe, and returns zero for any offset that is not mapped. The interrupt output is also registered. It follows the register contents with one clock of latency.

Top module: `fifo_evt_irq`

## Requirements
- R1: After a synchronous reset all three registers hold zero, the interrupt output is low and read data is zero.
- R2: The master enable word sits at byte offset 0x1C, the status word at 0x20 and the source enable word at 0x28. A read strobe at one of these offsets returns that register on `bus_rdata` in the following cycle. A read at any other offset returns zero.
- R3: Bit 31 of the master enable word is the only stored bit there. It is written from `bus_wdata[31]`, and every other bit of that word reads as zero.
- R4: The status and enable words share one layout: bit 3 is read FIFO full (`evt_in[3]`), bit 2 is write FIFO empty (`evt_in[2]`), bit 1 is read FIFO half full (`evt_in[1]`) and bit 0 is write FIFO half full (`evt_in[0]`). A 0-to-1 change on an event input sets its status bit at the next clock.
- R5: An event input that stays high does not set its status bit again once software has toggled that bit to zero. It must fall and rise again first.
- R6: Writing 1 to a status bit inverts it, and writing 0 leaves it unchanged. Status bits 31..4 read as zero.
- R7: When an event rising edge and a toggling write hit the same status bit in one cycle, the bit ends up set.
- R8: A write to the enable word stores bits 3..0 as given: 1 enables the source and 0 disables it. Bits 31..4 read as zero.
- R9: `irq` is high exactly one clock after the registers hold master enable = 1 and at least one status bit with its enable bit also set. Otherwise it is low.
- R10: A write to an unmapped offset changes none of the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 4 | Level event inputs, layout as in R4 |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench holds an event input high across a toggling clear. A design that detects levels instead of edges would set the bit again at once. It lines up an event edge with a toggling write on the same bit. A design that lets the write win would lose that event. It writes zeros and ones over already-set status bits, which exposes a design that clears on write instead of toggling. It also gates the interrupt separately through the master bit and through each source enable, and reads unmapped offsets. A decoder that aliases addresses or drops the master gate would then show wrong data or a stray interrupt.

// File: rtl/fifo_evt_irq_pkg.sv
package fifo_evt_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASTER,
    SEL_STATUS,
    SEL_ENABLE
  } reg_sel_e;
endpackage

// File: rtl/evt_rise_detect.sv
module evt_rise_detect #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lvl,
  output logic [NUM_SRC-1:0] rise
);
  logic [NUM_SRC-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~lvl_q[i];

    // a held level produces a single pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/evt_status_enable.sv
module evt_status_enable #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_status,
  input  logic               wr_enable,
  input  logic [NUM_SRC-1:0] wbits,
  input  logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable
);
  logic [NUM_SRC-1:0] toggle;

  assign toggle = wr_status ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status ^ toggle) | rise;
      if (wr_enable) enable <= wbits;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> status[i]);
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (rise[i] && wr_status && wbits[i]) |=> status[i]);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!rise[i] && !wr_status) |=> $stable(status[i]));
  end

  assert_enable_load_R8: assert property (@(posedge clk) disable iff (rst)
    wr_enable |=> (enable == $past(wbits)));
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] enable,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= master & |(status & enable);
  end

  assert_master_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !master |=> !irq);
  assert_no_source_R9: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) == '0) |=> !irq);
endmodule

// File: rtl/fifo_evt_irq.sv
module fifo_evt_irq
  import fifo_evt_irq_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 4,
  parameter int MASTER_BIT = 31,
  parameter int OFF_MASTER = 'h1C,
  parameter int OFF_STATUS = 'h20,
  parameter int OFF_ENABLE = 'h28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(OFF_MASTER);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);

  reg_sel_e           sel;
  logic               master;
  logic [NUM_SRC-1:0] rise, status, enable;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    if      (bus_addr == A_MASTER) sel = SEL_MASTER;
    else if (bus_addr == A_STATUS) sel = SEL_STATUS;
    else if (bus_addr == A_ENABLE) sel = SEL_ENABLE;
    else                           sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                              master <= 1'b0;
    else if (bus_wr && sel == SEL_MASTER) master <= bus_wdata[MASTER_BIT];
  end

  evt_rise_detect #(.NUM_SRC(NUM_SRC)) u_rise (
    .clk (clk), .rst (rst), .lvl (evt_in), .rise (rise)
  );

  evt_status_enable #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_status (bus_wr && sel == SEL_STATUS),
    .wr_enable (bus_wr && sel == SEL_ENABLE),
    .wbits     (bus_wdata[NUM_SRC-1:0]),
    .rise      (rise),
    .status    (status),
    .enable    (enable)
  );

  evt_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk (clk), .rst (rst), .master (master),
    .status (status), .enable (enable), .irq (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASTER: rd_mux[MASTER_BIT]    = master;
      SEL_STATUS: rd_mux[NUM_SRC-1:0]   = status;
      SEL_ENABLE: rd_mux[NUM_SRC-1:0]   = enable;
      default:    rd_mux                = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && bus_rdata == '0 && status == '0 && !master));
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_NONE) |=> ($stable(master) && $stable(enable)));
endmodule

// File: tb/fifo_evt_irq_test.sv
`timescale 1ns/1ps
module fifo_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_in;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  localparam logic [8:0] A_M = 9'h01C, A_S = 9'h020, A_E = 9'h028;

  always #2.5 clk = ~clk;

  fifo_evt_irq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [8:0] a, input logic [31:0] exp,
                            input string req);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic expect_irq(input logic exp, input string req);
    @(negedge clk);
    check(irq === exp, req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic clear_all();
    logic [31:0] v;
    rd(A_S, v);
    wr(A_S, v);
  endtask

  task automatic t_reset();
    check(irq === 1'b0 && bus_rdata === '0, "R1", {31'b0, irq}, 32'h0);
    expect_reg(A_M, 32'h0, "R1");
    expect_reg(A_S, 32'h0, "R1");
    expect_reg(A_E, 32'h0, "R1");
  endtask

  task automatic t_map();
    wr(A_M, 32'hFFFF_FFFF);
    expect_reg(A_M, 32'h8000_0000, "R3");
    wr(A_E, 32'hFFFF_FFF5);
    expect_reg(A_E, 32'h0000_0005, "R8");
    wr(A_E, 32'h0000_000A);
    expect_reg(A_E, 32'h0000_000A, "R8");
    expect_reg(9'h024, 32'h0, "R2");
    expect_reg(9'h100, 32'h0, "R2");
    wr(9'h024, 32'hFFFF_FFFF);
    wr(9'h11C, 32'h0);
    expect_reg(A_E, 32'h0000_000A, "R10");
    expect_reg(A_M, 32'h8000_0000, "R10");
    expect_reg(A_S, 32'h0, "R10");
    wr(A_M, 32'h7FFF_FFFF);
    expect_reg(A_M, 32'h0, "R3");
  endtask

  task automatic t_edges();
    for (int i = 0; i < 4; i++) begin
      evt_in = 4'(1 << i);
      @(negedge clk);
      evt_in = 4'h0;
      expect_reg(A_S, 32'(1 << i), "R4");
      wr(A_S, 32'(1 << i));
    end
    expect_reg(A_S, 32'h0, "R6");
  endtask

  task automatic t_toggle();
    wr(A_S, 32'hFFFF_FFF6);
    expect_reg(A_S, 32'h6, "R6");
    wr(A_S, 32'h0);
    expect_reg(A_S, 32'h6, "R6");
    wr(A_S, 32'h3);
    expect_reg(A_S, 32'h5, "R6");
    clear_all();
    expect_reg(A_S, 32'h0, "R6");
  endtask

  task automatic t_level_hold();
    evt_in = 4'b1000;
    @(negedge clk);
    wr(A_S, 32'h8);
    repeat (4) @(negedge clk);
    expect_reg(A_S, 32'h0, "R5");
    evt_in = 4'b0000;
    @(negedge clk);
    evt_in = 4'b1000;
    @(negedge clk);
    expect_reg(A_S, 32'h8, "R5");
    evt_in = 4'b0000;
    clear_all();
  endtask

  task automatic t_collide();
    evt_in = 4'b0010;
    @(negedge clk);
    evt_in = 4'b0000;
    expect_reg(A_S, 32'h2, "R7");
    evt_in = 4'b0010;
    wr(A_S, 32'h2);
    evt_in = 4'b0000;
    expect_reg(A_S, 32'h2, "R7");
    evt_in = 4'b0100;
    wr(A_S, 32'h4);
    evt_in = 4'b0000;
    expect_reg(A_S, 32'h6, "R7");
    clear_all();
  endtask

  task automatic t_irq();
    wr(A_M, 32'h0);
    wr(A_E, 32'h0);
    wr(A_S, 32'h1);
    expect_irq(1'b0, "R9");
    wr(A_E, 32'h2);
    expect_irq(1'b0, "R9");
    wr(A_M, 32'h8000_0000);
    expect_irq(1'b0, "R9");
    wr(A_E, 32'h1);
    check(irq === 1'b0, "R9", {31'b0, irq}, 32'h0);
    expect_irq(1'b1, "R9");
    wr(A_M, 32'h0);
    expect_irq(1'b0, "R9");
    wr(A_M, 32'h8000_0000);
    expect_irq(1'b1, "R9");
    wr(A_S, 32'h1);
    expect_irq(1'b0, "R9");
    wr(A_E, 32'hF);
    evt_in = 4'b1000;
    @(negedge clk);
    evt_in = 4'b0000;
    expect_irq(1'b1, "R9");
    clear_all();
    expect_irq(1'b0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_edges();
    t_toggle();
    t_level_hold();
    t_collide();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule